// File: doc/BRIEF.md
# Late-Arrival Detecting Output Register Bank

This block is the output register stage of a variable-latency multiplier. It holds the 2m-bit product. Each result bit is stored twice. A main flop samples the data on the main clock edge. A shadow flop samples the same wire one phase later. If the two copies disagree, the word reached the register after the main edge. The block then raises a one-cycle error pulse, which feeds the error counter of the hold logic. It also marks its output as not valid for that cycle and copies the shadow value into the main flop at the next edge.

In this synchronous model the delayed clock is a sample strobe, `late_smp`. The producer presents a word while the strobe is low. The main copy takes that word. In the next cycle the producer raises the strobe and presents the value the wire has settled to by then. The shadow copy takes that value, and the main copy keeps its word during that edge. A repair costs one extra cycle. During the repair the data input is not sampled.

Top module: `razor_reg_bank`

## Requirements
- R1: While reset is low, the held word `q_word` reads 0, `err_pulse` is low and `q_valid` is low.
- R2: On an edge with `late_smp` low and no error pending, the main copy loads `d_word`. From the next cycle `q_word` shows that word and `q_valid` is high.
- R3: On an edge with `late_smp` high and no error pending, the shadow copy loads `d_word` and `q_word` keeps its value.
- R4: If the word sampled under the strobe equals the held main word, `err_pulse` stays low and `q_valid` stays high.
- R5: If the two copies differ in any bit, `err_pulse` is high for exactly one cycle, the cycle right after the strobe edge.
- R6: While `err_pulse` is high, `q_valid` is low and `q_word` still shows the stale main word.
- R7: At the edge that ends the error cycle, the main copy is overwritten with the shadow copy and `d_word` is ignored. From the next cycle `q_word` equals the late word and `q_valid` is high.
- R8: A strobe raised during the error cycle is ignored. No new comparison is started, so `err_pulse` is low in the following cycle.
- R9: A difference in a single bit is flagged at every bit position, including bit 0 and the most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| late_smp | input | 1 | Delayed-phase sample strobe for the shadow copies |
| d_word | input | 2*M_W | Product word from the multiplier |
| q_word | output | 2*M_W | Held (main) word |
| err_pulse | output | 1 | OR of all per-bit copy mismatches, one cycle long |
| q_valid | output | 1 | `q_word` may be used downstream |

## Verification
A main load appears on `q_word` one cycle after its edge, because a single register lies on the path. A comparison result appears on `err_pulse` and `q_valid` in the cycle right after the strobe edge. The repaired word appears one cycle after that. The bench drives inputs on the falling edge and samples on the next falling edge, half a period after the edge that produced the result. For each vector it checks the held word and the flags in the cycle after the strobe. Only when an error is expected does it spend one more cycle checking the repaired word. Each check therefore lands on the exact cycle named in R2 through R7.

// File: rtl/razor_pkg.sv
package razor_pkg;

   // per-edge actions shared by every bit cell
   typedef struct packed {
      logic load_main;    // main copy takes the input word
      logic load_shadow;  // shadow copy takes the input word
      logic repair;       // main copy takes the shadow copy
   } cell_ctl_t;

   localparam int unsigned MIN_GROUP_W = 1;

endpackage

// File: rtl/razor_bit_cell.sv
module razor_bit_cell
   import razor_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      d_bit,
   input  cell_ctl_t ctl,
   input  logic      cmp_en,
   output logic      q_bit,
   output logic      mis_bit
);

   logic main_r;
   logic shadow_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_r <= 1'b0;
      end else if (ctl.repair) begin
         main_r <= shadow_r;
      end else if (ctl.load_main) begin
         main_r <= d_bit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_r <= 1'b0;
      end else if (ctl.load_shadow) begin
         shadow_r <= d_bit;
      end
   end

   assign q_bit   = main_r;
   assign mis_bit = cmp_en & (main_r ^ shadow_r);

   // R7
   repair_copies_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.repair |=> (main_r == $past(shadow_r)));

   // R3
   shadow_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.load_shadow |=> $stable(shadow_r));

endmodule

// File: rtl/razor_err_reduce.sv
module razor_err_reduce #(
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned GROUP_W = 4,
   parameter bit          GROUPED = 1'b1
) (
   input  logic [WIDTH-1:0] mis_vec,
   output logic             any_mis
);

   localparam int unsigned N_GRP = (WIDTH + GROUP_W - 1) / GROUP_W;

   if (GROUP_W < razor_pkg::MIN_GROUP_W) begin : g_bad_group
      $error("razor_err_reduce: GROUP_W must be at least 1");
   end

   if (GROUPED) begin : g_grouped
      logic [N_GRP-1:0] grp_or;
      always_comb begin
         grp_or = '0;
         for (int i = 0; i < int'(WIDTH); i++) begin
            grp_or[i / int'(GROUP_W)] = grp_or[i / int'(GROUP_W)] | mis_vec[i];
         end
      end
      assign any_mis = |grp_or;
   end else begin : g_flat
      assign any_mis = |mis_vec;
   end

endmodule

// File: rtl/razor_ctrl.sv
module razor_ctrl
   import razor_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      late_smp,
   input  logic      any_mis,
   output cell_ctl_t ctl,
   output logic      cmp_en,
   output logic      q_valid
);

   logic cmp_r;
   logic held_r;

   always_comb begin
      ctl.repair      = any_mis;
      ctl.load_main   = !late_smp && !any_mis;
      ctl.load_shadow = late_smp && !any_mis;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_r  <= 1'b0;
         held_r <= 1'b0;
      end else begin
         cmp_r <= ctl.load_shadow;
         if (ctl.load_main || ctl.repair) begin
            held_r <= 1'b1;
         end
      end
   end

   assign cmp_en  = cmp_r;
   assign q_valid = held_r && !any_mis;

   // R5
   err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_mis |=> !any_mis);

   // R8
   no_check_after_repair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_mis |=> !cmp_r);

endmodule

// File: rtl/razor_reg_bank.sv
module razor_reg_bank
   import razor_pkg::*;
#(
   parameter int unsigned M_W     = 4,
   parameter int unsigned GROUP_W = 4,
   parameter bit          GROUPED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               late_smp,
   input  logic [2*M_W-1:0]   d_word,
   output logic [2*M_W-1:0]   q_word,
   output logic               err_pulse,
   output logic               q_valid
);

   localparam int unsigned DATA_W = 2 * M_W;

   if (M_W < 1) begin : g_bad_width
      $error("razor_reg_bank: M_W must be at least 1");
   end

   cell_ctl_t         ctl;
   logic              cmp_en;
   logic [DATA_W-1:0] mis_vec;
   logic              any_mis;

   razor_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .late_smp (late_smp),
      .any_mis  (any_mis),
      .ctl      (ctl),
      .cmp_en   (cmp_en),
      .q_valid  (q_valid)
   );

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      razor_bit_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .d_bit   (d_word[b]),
         .ctl     (ctl),
         .cmp_en  (cmp_en),
         .q_bit   (q_word[b]),
         .mis_bit (mis_vec[b])
      );
   end

   razor_err_reduce #(
      .WIDTH   (DATA_W),
      .GROUP_W (GROUP_W),
      .GROUPED (GROUPED)
   ) u_reduce (
      .mis_vec (mis_vec),
      .any_mis (any_mis)
   );

   assign err_pulse = any_mis;

   // R3
   main_kept_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (late_smp && !err_pulse) |=> $stable(q_word));

   // R4
   match_no_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (late_smp && !err_pulse && (d_word == q_word)) |=> !err_pulse);

   // R5
   mismatch_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (late_smp && !err_pulse && (d_word != q_word)) |=> err_pulse);

   // R6
   invalid_in_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> !q_valid);

endmodule

// File: tb/razor_reg_bank_bench.sv
module razor_reg_bank_bench;

   localparam int CLK_PERIOD = 10;
   localparam int M_W        = 4;
   localparam int DW         = 2 * M_W;
   localparam int N_VEC      = 8;

   // {first word, late word, expected error}
   localparam logic [2*DW:0] VEC [0:N_VEC-1] = '{
      {8'h3C, 8'h3C, 1'b0},
      {8'hA5, 8'hA4, 1'b1},
      {8'h01, 8'h81, 1'b1},
      {8'h00, 8'hFF, 1'b1},
      {8'hFF, 8'hFF, 1'b0},
      {8'h5A, 8'h5B, 1'b1},
      {8'h80, 8'h00, 1'b1},
      {8'h12, 8'h12, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          late_smp = 1'b0;
   logic [DW-1:0] d_word = '0;
   logic [DW-1:0] q_word;
   logic          err_pulse;
   logic          q_valid;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   razor_reg_bank #(.M_W(M_W)) u_razor_reg_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .late_smp  (late_smp),
      .d_word    (d_word),
      .q_word    (q_word),
      .err_pulse (err_pulse),
      .q_valid   (q_valid)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // one word then its late value under the strobe
   task automatic run_pair(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic exp_err);
      @(negedge clk);
      d_word = a; late_smp = 1'b0;
      @(negedge clk);
      check("R2 word loaded", q_word, a);
      check("R2 valid", q_valid, 1'b1);
      d_word = b; late_smp = 1'b1;
      @(negedge clk);
      late_smp = 1'b0;
      check("R3 main kept", q_word, a);
      check(exp_err ? "R5 R9 error raised" : "R4 no error", err_pulse, exp_err);
      check("R6 valid", q_valid, !exp_err);
      if (exp_err) begin
         d_word = ~b;
         @(negedge clk);
         check("R7 repaired word", q_word, b);
         check("R5 single pulse", err_pulse, 1'b0);
         check("R7 valid", q_valid, 1'b1);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 q_word", q_word, '0);
      check("R1 err", err_pulse, 1'b0);
      check("R1 valid", q_valid, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < N_VEC; i++) begin
         run_pair(VEC[i][2*DW:DW+1], VEC[i][DW:1], VEC[i][0]);
      end

      // R2: back-to-back plain loads
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         d_word = DW'(8'h11 * (k + 1)); late_smp = 1'b0;
         @(negedge clk);
         check("R2 stream", q_word, DW'(8'h11 * (k + 1)));
      end

      // R9: single-bit difference at each position
      for (int b = 0; b < DW; b++) begin
         run_pair(8'h00, DW'(1) << b, 1'b1);
      end

      // R8: strobe held high through the error cycle
      @(negedge clk);
      d_word = 8'h0F; late_smp = 1'b0;
      @(negedge clk);
      d_word = 8'hF0; late_smp = 1'b1;
      @(negedge clk);
      check("R8 error raised", err_pulse, 1'b1);
      d_word = 8'h33; late_smp = 1'b1;
      @(negedge clk);
      late_smp = 1'b0;
      check("R8 repaired", q_word, 8'hF0);
      @(negedge clk);
      check("R8 no new check", err_pulse, 1'b0);
      check("R8 word kept", q_word, 8'h33);

      // R1: reset during an error cycle
      @(negedge clk);
      d_word = 8'h44; late_smp = 1'b0;
      @(negedge clk);
      d_word = 8'h45; late_smp = 1'b1;
      @(negedge clk);
      late_smp = 1'b0;
      check("R5 error before reset", err_pulse, 1'b1);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 err cleared", err_pulse, 1'b0);
      check("R1 word cleared", q_word, '0);
      check("R1 valid cleared", q_valid, 1'b0);
      rst_n = 1'b1;

      finished = 1'b1;
      summary();
   end

endmodule